// File: doc/BRIEF.md
# Dual-Clock FIFO with 2:1 Width Narrowing

This block carries data between two unrelated clock domains. The producer pushes 16-bit words on the write clock. The consumer pulls 8-bit bytes on the read clock, which typically runs at twice the write rate. Every word comes out as two bytes, most significant byte first. The queue holds `DEPTH` words, which is `2*DEPTH` bytes, and the default `DEPTH` is 2048.

Each side has its own status. The write side reports full, almost full, a per-word acknowledge and its fill level in words. The read side reports empty, almost empty, a per-byte valid strobe and its fill level in bytes. The position counters pass between the domains as Gray codes through two-flop synchronizers. Because of this, each side sees the far side's progress a few cycles late. Its full and empty flags are therefore never optimistic. One active-low reset input clears both domains, and each domain samples it on its own clock.

Top module: `dcf_top`

## Requirements
- R1: After reset, empty is 1 and full, almost_full, almost_empty, wr_ack and valid are 0. Both counts read 0 and rd_data reads 0.
- R2: Each accepted word returns as two successive accepted reads. The first read gives bits [15:8] and the second gives bits [7:0].
- R3: Bytes leave in the order their words were written, including while both sides are active at the same time.
- R4: full is 1 when wr_count equals DEPTH. A write presented while full is dropped: no wr_ack follows and the stored data and counts do not change.
- R5: A read presented while empty is dropped: valid stays 0, rd_data holds its value and rd_count does not change.
- R6: almost_full is 1 exactly when wr_count equals DEPTH-1.
- R7: almost_empty is 1 exactly when rd_count equals 1.
- R8: wr_ack is 1 in the write-clock cycle after each accepted write (wr_en high while full is low) and 0 otherwise.
- R9: valid is 1 in the read-clock cycle after each accepted read (rd_en high while empty is low), and rd_data changes only together with valid.
- R10: Once both sides have been idle for four write-clock cycles, wr_count equals the words written minus floor(bytes read / 2), and rd_count equals twice the words written minus the bytes read. wr_count never exceeds DEPTH and rd_count never exceeds 2*DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled by each domain on its own clock |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W (16) | Word to store |
| full | output | 1 | No free word slot |
| almost_full | output | 1 | Exactly one free word slot |
| wr_ack | output | 1 | Previous write cycle was accepted |
| wr_count | output | AW+1 | Occupancy in words, as seen from the write side |
| rd_en | input | 1 | Read request |
| rd_data | output | WR_W/2 (8) | Registered byte output |
| valid | output | 1 | rd_data was loaded by the previous read cycle |
| empty | output | 1 | No byte available |
| almost_empty | output | 1 | Exactly one byte available |
| rd_count | output | AW+2 | Occupancy in bytes, as seen from the read side |

## Verification
The bench uses an eight-word configuration. It fills the queue one word at a time up to capacity and one word past it, and checks both counts and all four flags after every step. This separates the full and almost-full thresholds and the handling of a dropped write. It then drains byte by byte, with each word holding a distinct upper and lower byte. This shows whether the lane order is right and whether a half-read word still blocks its slot. Finally, a ramp is pushed and pulled concurrently under the real clock ratio. This separates correct Gray-coded pointer crossing from corruption or reordering when pointers wrap under load.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock narrowing FIFO.
// Assumes: the read byte is exactly half a write word (2:1 ratio).
package dcf_pkg;

    // Flops in each pointer synchronizer chain.
    localparam int SYNC_STAGES = 2;

    // Byte lane within a stored word; the upper lane leaves first.
    typedef enum logic {
        LANE_UPPER = 1'b0,
        LANE_LOWER = 1'b1
    } lane_e;

endpackage

// File: rtl/dcf_sync.sv
// Multi-bit flop chain for moving a Gray-coded pointer into another clock
// domain. Assumes: the input changes at most one bit per source clock.
module dcf_sync #(
    parameter int W      = 4,
    parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    // First stage captures the foreign-domain value.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    // Remaining stages settle metastability.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: word pointer, its Gray copy for crossing, and the
// write-side flags and count. Assumes: rwgray_s is the read side's
// completed-word pointer, already synchronized into wr_clk.
module dcf_wr_side #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic        wr_clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rwgray_s,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        wr_go,
    output logic        full,
    output logic        almost_full,
    output logic        wr_ack,
    output logic [AW:0] wr_count
);

    logic [AW:0] rwbin;
    logic [AW:0] wptr_nx;

    // Convert the synchronized Gray pointer back to binary.
    always_comb begin
        rwbin[AW] = rwgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rwbin[i] = rwbin[i+1] ^ rwgray_s[i];
        end
    end

    // Occupancy and flags from the local pointer and the delayed remote one.
    always_comb begin
        wr_count    = wptr - rwbin;
        full        = (wr_count == (AW+1)'(DEPTH));
        almost_full = (wr_count == (AW+1)'(DEPTH - 1));
        wr_go       = wr_en && !full;
        wptr_nx     = wptr + 1'b1;
    end

    // Advance the pointer and strobe the acknowledge on accepted writes.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            wgray  <= '0;
            wr_ack <= 1'b0;
        end else begin
            wr_ack <= wr_go;
            if (wr_go) begin
                wptr  <= wptr_nx;
                wgray <= wptr_nx ^ (wptr_nx >> 1);
            end
        end
    end

endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: byte pointer, the Gray copy of its completed-word part
// for crossing, and the read-side flags and count. Assumes: wgray_s is the
// write pointer, already synchronized into rd_clk.
module dcf_rd_side #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic [AW+1:0] rptr,
    output logic [AW:0]   rwgray,
    output logic          rd_go,
    output logic          empty,
    output logic          almost_empty,
    output logic          valid,
    output logic [AW+1:0] rd_count
);

    logic [AW:0]   wbin;
    logic [AW+1:0] rptr_nx;
    logic [AW:0]   rword_nx;

    // Convert the synchronized Gray write pointer back to binary.
    always_comb begin
        wbin[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
    end

    // Byte occupancy: two bytes per written word, minus bytes consumed.
    always_comb begin
        rd_count     = {wbin, 1'b0} - rptr;
        empty        = (rd_count == '0);
        almost_empty = (rd_count == (AW+2)'(1));
        rd_go        = rd_en && !empty;
        rptr_nx      = rptr + 1'b1;
        rword_nx     = rptr_nx[AW+1:1];
    end

    // Advance the byte pointer and strobe valid on accepted reads.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rptr   <= '0;
            rwgray <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= rd_go;
            if (rd_go) begin
                rptr   <= rptr_nx;
                rwgray <= rword_nx ^ (rword_nx >> 1);
            end
        end
    end

endmodule

// File: rtl/dcf_store.sv
// Word-wide storage written on wr_clk, read one byte lane at a time on rd_clk
// through an output register. Assumes: the control logic never reads a
// word that has not yet been written.
module dcf_store #(
    parameter  int DEPTH = 2048,
    parameter  int WR_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int RD_W  = WR_W / 2
) (
    input  logic            wr_clk,
    input  logic            wr_go,
    input  logic [AW-1:0]   waddr,
    input  logic [WR_W-1:0] wdata,
    input  logic            rd_clk,
    input  logic            rst_n,
    input  logic            rd_go,
    input  logic [AW-1:0]   raddr,
    input  dcf_pkg::lane_e  lane,
    output logic [RD_W-1:0] rd_data
);

    logic [WR_W-1:0] mem [DEPTH];
    logic [RD_W-1:0] lane_q [2];

    // Store accepted words.
    always_ff @(posedge wr_clk) begin
        if (wr_go) mem[waddr] <= wdata;
    end

    // Split the addressed word into its two lanes, upper lane at index 0.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_q[g] = mem[raddr][WR_W-1-g*RD_W -: RD_W];
    end

    // Register the selected byte on accepted reads.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_go) rd_data <= lane_q[lane];
    end

endmodule

// File: rtl/dcf_top.sv
// Dual-clock FIFO taking WR_W-bit words and returning WR_W/2-bit bytes,
// upper byte first. Assumes: DEPTH is a power of two; rst_n is held low
// for several cycles of both clocks.
module dcf_top #(
    parameter  int DEPTH = 2048,
    parameter  int WR_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int RD_W  = WR_W / 2
) (
    input  logic            wr_clk,
    input  logic            rd_clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            full,
    output logic            almost_full,
    output logic            wr_ack,
    output logic [AW:0]     wr_count,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            valid,
    output logic            empty,
    output logic            almost_empty,
    output logic [AW+1:0]   rd_count
);

    logic [AW:0]    wptr, wgray, wgray_s;
    logic [AW+1:0]  rptr;
    logic [AW:0]    rwgray, rwgray_s;
    logic           wr_go, rd_go;
    dcf_pkg::lane_e lane;

    assign lane = dcf_pkg::lane_e'(rptr[0]);

    dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rwgray_s(rwgray_s),
        .wptr(wptr), .wgray(wgray), .wr_go(wr_go), .full(full),
        .almost_full(almost_full), .wr_ack(wr_ack), .wr_count(wr_count)
    );

    dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
        .rptr(rptr), .rwgray(rwgray), .rd_go(rd_go), .empty(empty),
        .almost_empty(almost_empty), .valid(valid), .rd_count(rd_count)
    );

    dcf_sync #(.W(AW+1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(AW+1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rwgray), .q(rwgray_s)
    );

    dcf_store #(.DEPTH(DEPTH), .WR_W(WR_W)) u_mem (
        .wr_clk(wr_clk), .wr_go(wr_go), .waddr(wptr[AW-1:0]), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_go(rd_go),
        .raddr(rptr[AW:1]), .lane(lane), .rd_data(rd_data)
    );

endmodule

// Temporal checks on the FIFO's port behaviour, one per property-expressible
// requirement. Assumes: attached to dcf_top through the bind below.
module dcf_chk #(
    parameter  int DEPTH = 2048,
    parameter  int WR_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int RD_W  = WR_W / 2
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            almost_full,
    input logic            wr_ack,
    input logic [AW:0]     wr_count,
    input logic [RD_W-1:0] rd_data,
    input logic            valid,
    input logic            empty,
    input logic            almost_empty,
    input logic [AW+1:0]   rd_count
);

    assert_reject_full_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && full) |=> !wr_ack);

    assert_ack_after_write_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !full) |=> wr_ack);

    assert_almost_full_level_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        almost_full |-> (wr_count == (AW+1)'(DEPTH - 1)));

    assert_almost_empty_level_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        almost_empty |-> (rd_count == (AW+2)'(1)));

    assert_empty_read_dropped_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && empty) |=> (!valid && $stable(rd_data)));

    assert_valid_after_read_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && !empty) |=> valid);

    assert_no_overflow_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_count <= (AW+1)'(DEPTH));

    assert_byte_bound_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_count <= (AW+2)'(2 * DEPTH));

endmodule

bind dcf_top dcf_chk #(.DEPTH(DEPTH), .WR_W(WR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .rd_en(rd_en), .full(full), .almost_full(almost_full), .wr_ack(wr_ack),
    .wr_count(wr_count), .rd_data(rd_data), .valid(valid), .empty(empty),
    .almost_empty(almost_empty), .rd_count(rd_count)
);

// File: tb/dcf_top_tb.sv
// Bench for dcf_top in an eight-word configuration: step fill, step drain,
// then a concurrent ramp. Expected values come from a byte queue model.
module dcf_top_tb;

    localparam int D  = 8;
    localparam int AW = $clog2(D);

    logic          wr_clk, rd_clk, rst_n;
    logic          wr_en, rd_en;
    logic [15:0]   wr_data;
    logic          full, almost_full, wr_ack, valid, empty, almost_empty;
    logic [AW:0]   wr_count;
    logic [AW+1:0] rd_count;
    logic [7:0]    rd_data;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 0;
    byte    model[$];
    logic [7:0] last_byte = 8'h00;
    int     words_in = 0;
    int     bytes_out = 0;

    dcf_top #(.DEPTH(D), .WR_W(16)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .almost_full(almost_full), .wr_ack(wr_ack), .wr_count(wr_count),
        .rd_en(rd_en), .rd_data(rd_data), .valid(valid), .empty(empty),
        .almost_empty(almost_empty), .rd_count(rd_count)
    );

    // Read clock at 250 MHz (period 4); write clock at half, phase-shifted.
    initial begin
        rd_clk = 0;
        forever #2 rd_clk = ~rd_clk;
    end
    initial begin
        wr_clk = 0;
        #1;
        forever #4 wr_clk = ~wr_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic wr_word(input logic [15:0] d, output bit acc);
        @(negedge wr_clk);
        acc     = !full;
        wr_en   = 1'b1;
        wr_data = d;
        if (acc) begin
            model.push_back(d[15:8]);
            model.push_back(d[7:0]);
            words_in++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        chk(wr_ack == acc, "R8 wr_ack", int'(wr_ack), int'(acc));
    endtask

    task automatic rd_byte(output bit acc);
        logic [7:0] exp_b;
        @(negedge rd_clk);
        acc   = !empty;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk(valid == acc, "R9 valid", int'(valid), int'(acc));
        if (acc) begin
            exp_b = model.pop_front();
            bytes_out++;
            chk(rd_data == exp_b, "R2/R3 byte order", int'(rd_data), int'(exp_b));
            last_byte = rd_data;
        end else begin
            chk(rd_data == last_byte, "R5 rd_data held", int'(rd_data), int'(last_byte));
        end
    endtask

    task automatic settle_and_check();
        int wexp, rexp;
        repeat (4) @(negedge wr_clk);
        wexp = words_in - bytes_out / 2;
        rexp = 2 * words_in - bytes_out;
        chk(int'(wr_count) == wexp, "R10 wr_count", int'(wr_count), wexp);
        chk(int'(rd_count) == rexp, "R10 rd_count", int'(rd_count), rexp);
        chk(full == (wexp == D), "R4 full", int'(full), int'(wexp == D));
        chk(almost_full == (wexp == D - 1), "R6 almost_full", int'(almost_full), int'(wexp == D - 1));
        chk(empty == (rexp == 0), "R5 empty", int'(empty), int'(rexp == 0));
        chk(almost_empty == (rexp == 1), "R7 almost_empty", int'(almost_empty), int'(rexp == 1));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit acc;
        rst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
        repeat (6) @(negedge wr_clk);
        rst_n = 1;
        @(negedge rd_clk);

        // R1: reset state.
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(full == 1'b0, "R1 full", int'(full), 0);
        chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);
        chk(almost_empty == 1'b0, "R1 almost_empty", int'(almost_empty), 0);
        chk(wr_ack == 1'b0, "R1 wr_ack", int'(wr_ack), 0);
        chk(valid == 1'b0, "R1 valid", int'(valid), 0);
        chk(wr_count == '0, "R1 wr_count", int'(wr_count), 0);
        chk(rd_count == '0, "R1 rd_count", int'(rd_count), 0);
        chk(rd_data == 8'h00, "R1 rd_data", int'(rd_data), 0);

        // R5: read while empty is dropped.
        rd_byte(acc);
        chk(acc == 1'b0, "R5 no accept when empty", int'(acc), 0);
        settle_and_check();

        // Step fill to capacity, then one past it (R4, R6, R8, R10).
        for (int i = 0; i <= D; i++) begin
            wr_word({8'(8'hA0 + i), 8'(8'h30 + 3 * i)}, acc);
            chk(acc == (i < D), "R4 write accepted below capacity", int'(acc), int'(i < D));
            settle_and_check();
        end

        // One byte out: the half-read word still blocks its slot (R4).
        rd_byte(acc);
        settle_and_check();
        wr_word(16'hDEAD, acc);
        chk(acc == 1'b0, "R4 write dropped with half-read word", int'(acc), 0);
        settle_and_check();

        // Step drain to empty, then one past it (R2, R3, R5, R7, R10).
        for (int i = 0; i < 2 * D; i++) begin
            rd_byte(acc);
            settle_and_check();
        end
        chk(bytes_out == 2 * D, "R3 bytes drained", bytes_out, 2 * D);

        // Concurrent ramp at the real clock ratio (R3, R8, R9).
        fork
            begin
                int n = 0;
                while (n < 3 * D) begin
                    wr_word(16'(n), acc);
                    if (acc) n++;
                end
            end
            begin
                int got = 0;
                bit racc;
                while (got < 6 * D) begin
                    rd_byte(racc);
                    if (racc) got++;
                end
            end
        join
        settle_and_check();
        chk(model.size() == 0, "R3 model drained", model.size(), 0);

        summary();
    end

endmodule